// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Each lane sends seven bits per pixel period. The whole block runs on one fast clock at seven times the pixel rate. A one-cycle boundary strobe, asserted once every seven fast cycles, marks where each pixel word begins. The 28 input bits are spread over lanes and bit slots by a fixed, non-sequential mapping. A receiver recovers the word by using the forwarded clock to find slot 0.

The word presented while the strobe is high is captured. It is shifted out in the pixel period that starts at the next strobe, so the latency is exactly one pixel period.

An active-low shutdown input parks every output at 0 and drops an output-enable flag. After shutdown is released, a valid flag rises only once a lock interval, counted in fast clock cycles, has passed.

Top module: `pix7_link_tx`

## Requirements
- R1: While `rstN` is low, `laneData`, `clkLane`, `outEnable` and `linkValid` are all 0.
- R2: `pixWord` is captured on the clock edge at which `frameStrobe` is high. That word is sent during the seven fast cycles that begin at the next strobe edge, so latency is one pixel period.
- R3: Bit slot s is the s-th fast cycle after the strobe edge, with s counting 0 to 6. The slot-to-bit mapping, listed by lane as input-bit indices for slots 0 to 6, is:
  - lane 0 carries bits 1,0,7,6,4,3,2
  - lane 1 carries bits 9,8,18,15,14,13,12
  - lane 2 carries bits 20,19,26,25,24,22,21
  - lane 3 carries bits 5,27,23,17,16,11,10
- R4: While enabled, `clkLane` is 1 in slots 0 to 3 and 0 in slots 4 to 6. Its rising edge therefore marks slot 0, and its period equals one pixel period.
- R5: Changes on `pixWord` in cycles where `frameStrobe` is low have no effect on the transmitted data.
- R6: One cycle after `shutdownN` is sampled low, all lane outputs and `clkLane` are 0, and `outEnable` and `linkValid` are both 0.
- R7: `outEnable` is 1 one cycle after `shutdownN` is sampled high. `linkValid` rises exactly `LOCK_CYCLES` clock edges after the first edge at which `shutdownN` is high.
- R8: A shutdown pulse during the lock interval restarts it. `linkValid` then waits a full `LOCK_CYCLES` edges after the last release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven times the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | One-cycle pixel boundary strobe |
| pixWord | input | 28 | Parallel pixel word |
| shutdownN | input | 1 | Active-low shutdown |
| laneData | output | 4 | Serial data lanes |
| clkLane | output | 1 | Forwarded clock lane |
| outEnable | output | 1 | Outputs are driven (not parked) |
| linkValid | output | 1 | Lock interval has elapsed |

## Verification
The word path is exercised with several kinds of words, and each kind exposes a different class of fault:
- All-zero and all-one words catch stuck lanes.
- A walking single-one word over all 28 positions pins every bit to its own lane and slot, which exposes any swapped entry in the mapping.
- Alternating-bit words catch errors in neighbouring slot order.
- Random words, with random junk on the input between strobes, check the one-period latency and that non-strobe cycles are ignored.

The bench deserializes each frame and checks the forwarded clock's four-high, three-low pattern. It also times the lock interval after a clean release and after a release that is interrupted by a short shutdown pulse.

// File: rtl/pix7_pkg.sv
package pix7_pkg;
  localparam int LANES          = 4;
  localparam int SLOTS          = 7;
  localparam int WORD_W         = LANES * SLOTS;
  localparam int CLK_HIGH_SLOTS = 4;

  // Forwarded clock waveform, slot 0 in bit 0.
  localparam logic [SLOTS-1:0] CLK_PATTERN = SLOTS'((1 << CLK_HIGH_SLOTS) - 1);

  // Input-bit index sent by each lane in each slot.
  localparam int SLOT_SRC [LANES][SLOTS] = '{
    '{ 1,  0,  7,  6,  4,  3,  2},
    '{ 9,  8, 18, 15, 14, 13, 12},
    '{20, 19, 26, 25, 24, 22, 21},
    '{ 5, 27, 23, 17, 16, 11, 10}
  };

  typedef struct packed {
    logic capture;  // load the hold register from the input word
    logic reload;   // reload shifters, slot 0 starts next cycle
    logic drive;    // outputs are driven rather than parked
  } ctrl_strobe_t;
endpackage

// File: rtl/pix7_ctrl.sv
module pix7_ctrl
  import pix7_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStrobe,
  input  logic         shutdownN,
  output ctrl_strobe_t strobes,
  output logic         lockDone
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCK_CYCLES);

  logic              runQ;
  logic [LOCK_W-1:0] lockCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      lockCnt <= '0;
    end else begin
      runQ <= shutdownN;
      if (!shutdownN) begin
        lockCnt <= '0;
      end else if (lockCnt != LOCK_END) begin
        lockCnt <= lockCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capture = frameStrobe;
    strobes.reload  = frameStrobe;
    strobes.drive   = runQ;
  end

  assign lockDone = (lockCnt == LOCK_END);
endmodule

// File: rtl/pix7_datapath.sv
module pix7_datapath
  import pix7_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic [WORD_W-1:0] pixWord,
  output logic [LANES-1:0]  laneData,
  output logic              clkLane
);
  logic [WORD_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.capture) begin
      holdReg <= pixWord;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] slotBits;
    logic [SLOTS-1:0] shiftReg;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slotBits[s] = holdReg[SLOT_SRC[l][s]];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (strobes.reload) begin
        shiftReg <= slotBits;
      end else begin
        shiftReg <= shiftReg >> 1;
      end
    end

    assign laneData[l] = strobes.drive & shiftReg[0];
  end

  logic [SLOTS-1:0] clkShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkShift <= '0;
    end else if (strobes.reload) begin
      clkShift <= CLK_PATTERN;
    end else begin
      clkShift <= clkShift >> 1;
    end
  end

  assign clkLane = strobes.drive & clkShift[0];
endmodule

// File: rtl/pix7_link_tx.sv
module pix7_link_tx
  import pix7_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic [WORD_W-1:0] pixWord,
  input  logic              shutdownN,
  output logic [LANES-1:0]  laneData,
  output logic              clkLane,
  output logic              outEnable,
  output logic              linkValid
);
  ctrl_strobe_t strobes;
  logic         lockDone;

  pix7_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .shutdownN   (shutdownN),
    .strobes     (strobes),
    .lockDone    (lockDone)
  );

  pix7_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pixWord  (pixWord),
    .laneData (laneData),
    .clkLane  (clkLane)
  );

  assign outEnable = strobes.drive;
  assign linkValid = strobes.drive & lockDone;
endmodule

// File: rtl/pix7_link_tx_chk.sv
module pix7_link_tx_chk
  import pix7_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStrobe,
  input logic [WORD_W-1:0] pixWord,
  input logic              shutdownN,
  input logic [LANES-1:0]  laneData,
  input logic              clkLane,
  input logic              outEnable,
  input logic              linkValid
);
  localparam int ON_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [ON_W-1:0] ON_END = ON_W'(LOCK_CYCLES);

  logic [2:0]      sinceStrobe;
  logic [ON_W-1:0] onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStrobe <= 3'd7;
      onCnt       <= '0;
    end else begin
      if (frameStrobe) sinceStrobe <= 3'd1;
      else if (sinceStrobe != 3'd7) sinceStrobe <= sinceStrobe + 3'd1;
      if (!shutdownN) onCnt <= '0;
      else if (onCnt != ON_END) onCnt <= onCnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (laneData == '0 && !clkLane && !outEnable && !linkValid));

  // R6
  shutdown_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |=> (laneData == '0 && !clkLane && !outEnable && !linkValid));

  // R4
  clk_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && shutdownN) |=> clkLane);

  // R4
  clk_high_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEnable && sinceStrobe >= 3'd1 && sinceStrobe <= 3'd4) |-> clkLane);

  // R4
  clk_low_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceStrobe >= 3'd5) |-> !clkLane);

  // R7
  valid_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> (onCnt == ON_END && outEnable));

  // R8
  lock_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (onCnt == ON_END) |-> linkValid);
endmodule

bind pix7_link_tx pix7_link_tx_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (.*);

// File: tb/pix7_link_tx_tb.sv
module pix7_link_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 64;
  localparam int BMAP [4][7] = '{
    '{ 1,  0,  7,  6,  4,  3,  2},
    '{ 9,  8, 18, 15, 14, 13, 12},
    '{20, 19, 26, 25, 24, 22, 21},
    '{ 5, 27, 23, 17, 16, 11, 10}
  };

  logic        clk = 1'b0;
  logic        rstN, frameStrobe, shutdownN;
  logic [27:0] pixWord;
  logic [3:0]  laneData;
  logic        clkLane, outEnable, linkValid;

  int          checks = 0;
  int          fails  = 0;
  logic [27:0] expHold = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pix7_link_tx #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .pixWord     (pixWord),
    .shutdownN   (shutdownN),
    .laneData    (laneData),
    .clkLane     (clkLane),
    .outEnable   (outEnable),
    .linkValid   (linkValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Sends one pixel period starting from a falling edge; deserializes the
  // previous word from the lanes using the forwarded clock for slot alignment.
  task automatic sendFrame(input logic [27:0] w, input bit expectOff);
    logic [27:0] got;
    logic [6:0]  clkSeen;
    logic        anyOn;
    got = '0; clkSeen = '0; anyOn = 1'b0;
    for (int k = 0; k < 7; k++) begin
      frameStrobe = (k == 0);
      pixWord     = (k == 0) ? w : 28'($urandom);  // R5: junk between strobes
      @(posedge clk);
      @(negedge clk);
      clkSeen[k] = clkLane;
      if (laneData != 4'd0 || clkLane || outEnable || linkValid) anyOn = 1'b1;
      for (int l = 0; l < 4; l++) got[BMAP[l][k]] = laneData[l];
    end
    frameStrobe = 1'b0;
    if (expectOff) begin
      check(!anyOn, "R6", "outputs not parked in shutdown", 32'(anyOn), 32'd0);
    end else begin
      check(got == expHold, "R3", "deserialized word (R2 latency, R5)",
            32'(got), 32'(expHold));
      check(clkSeen == 7'b0001111, "R4", "clock slot pattern",
            32'(clkSeen), 32'h0f);
    end
    expHold = w;
  endtask

  task automatic waitLock(input string req);
    int n;
    n = 0;
    shutdownN = 1'b1;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) check(outEnable, req, "outEnable after release", 32'(outEnable), 32'd1);
    end while (!linkValid && n < LOCK + 10);
    check(n == LOCK, req, "lock interval length", 32'(n), 32'(LOCK));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1357));
    rstN = 1'b0; shutdownN = 1'b0; frameStrobe = 1'b0; pixWord = '0;
    repeat (3) @(negedge clk);
    check(laneData == 0 && !clkLane && !outEnable && !linkValid, "R1",
          "reset outputs", {25'd0, laneData, clkLane, outEnable, linkValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    waitLock("R7");

    sendFrame(28'h0000000, 1'b0);
    sendFrame(28'hfffffff, 1'b0);
    for (int b = 0; b < 28; b++) sendFrame(28'd1 << b, 1'b0);
    sendFrame(28'h5555555, 1'b0);
    sendFrame(28'haaaaaaa, 1'b0);
    for (int i = 0; i < 40; i++) sendFrame(28'($urandom), 1'b0);

    // R6: shutdown parks outputs while words keep arriving
    shutdownN = 1'b0;
    sendFrame(28'($urandom), 1'b1);
    sendFrame(28'($urandom), 1'b1);

    // R8: interrupted lock restarts the count
    shutdownN = 1'b1;
    repeat (LOCK - 3) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(!linkValid, "R8", "valid before lock end", 32'(linkValid), 32'd0);
    shutdownN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!outEnable && !linkValid, "R8", "pulse parks outputs",
          {30'd0, outEnable, linkValid}, 32'd0);
    waitLock("R8");

    for (int i = 0; i < 10; i++) sendFrame(28'($urandom), 1'b0);

    finishRun();
  end
endmodule